// File: doc/BRIEF.md
# Vectored Interrupt Offset Generator

This block works out the byte offset that is added to the exception base when an external interrupt is taken. It also reports which vector number was selected. It combines the eight pending interrupt lines with the eight interrupt mask bits. It then resolves a vector number in one of two ways: a priority scan inside the block, or the masked value taken directly as a number from an outside interrupt controller. That number is multiplied by a programmable spacing and placed above a fixed vectored base of 0x200.

When neither vectored scheme is enabled, the block falls back to one of two non-vectored entry points. If the dedicated-interrupt-vector bit is set, the offset is 0x200. Otherwise it is the general exception offset 0x180. Both outputs are combinational. The block also provides a copy of them registered once, for paths that need an extra stage to close timing.

Top module: `vio_offset_gen`

## Requirements
- R1: Only pending lines whose mask bit is 1 count; a pending line with mask bit 0 has no effect on the vector or the offset.
- R2: In internal priority mode (`vect_int_i`=1) the vector is the index of the highest set bit among bits 7..1 of the masked pending value.
- R3: In internal priority mode, if bits 7..1 of the masked pending value are all zero, the vector is 0, whatever bit 0 holds.
- R4: In external-controller mode (`vect_ext_i`=1, `vect_int_i`=0) the vector equals the 8-bit masked pending value read as an unsigned number.
- R5: In either vectored mode the offset is 0x200 + vector × (spacing × 32), where spacing is the unsigned 5-bit `spacing_i`; the maximum is 0x3DE20.
- R6: When both mode inputs are 1, internal priority mode is used.
- R7: With both mode inputs 0 and `iv_i`=1, the offset is 0x200 and the vector is 0.
- R8: With both mode inputs 0 and `iv_i`=0, the offset is 0x180 and the vector is 0.
- R9: In either vectored mode, a spacing of 0 gives an offset of exactly 0x200 for every vector.
- R10: `offset_q`/`vector_q` equal the combinational outputs of the previous clock edge; a synchronous active-low reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 8 | Pending interrupt lines |
| mask_i | input | 8 | Interrupt mask, 1 = enabled |
| iv_i | input | 1 | Dedicated interrupt vector select (non-vectored modes only) |
| vect_int_i | input | 1 | Enable internal priority vectoring |
| vect_ext_i | input | 1 | Enable external-controller vectoring |
| spacing_i | input | 5 | Vector spacing in units of 32 bytes |
| offset_o | output | 19 | Combinational offset from the exception base |
| vector_o | output | 8 | Combinational selected vector number |
| offset_q | output | 19 | Registered offset |
| vector_q | output | 8 | Registered vector number |

## Verification
The block holds no state apart from the output register. A wrong mode decode or a wrong priority scan therefore shows on `vector_o` or `offset_o` as soon as the inputs settle, and on the registered pair one edge later. The stimulus combines masks that hide the highest pending line, patterns that only bit 0 sets, both mode bits set at once, and spacing at 0 and at 31. A mis-ordered scan, an unmasked input, a wrong mode priority or a truncated product each produces an offset that differs from the expected value within that same cycle.

// File: rtl/vio_pkg.sv
// Package for the vectored interrupt offset generator.
// Holds the mode encoding and the fixed entry offsets that every submodule shares.
package vio_pkg;

    // Resolved interrupt entry scheme
    typedef enum logic [1:0] {
        VM_GENERAL   = 2'd0,
        VM_DEDICATED = 2'd1,
        VM_PRIORITY  = 2'd2,
        VM_EXTERNAL  = 2'd3
    } vmode_e;

    localparam int unsigned GENERAL_OFFSET = 32'h180;
    localparam int unsigned VECTOR_BASE    = 32'h200;
    localparam int unsigned SPACING_SHIFT  = 5;

endpackage

// File: rtl/vio_mode_sel.sv
// Mode selector.
// Turns the three configuration bits into one entry scheme.
// Assumes internal priority vectoring wins when both vectored enables are set.
module vio_mode_sel
    import vio_pkg::*;
(
    input  logic   iv_i,
    input  logic   vect_int_i,
    input  logic   vect_ext_i,
    output vmode_e mode_o
);

    // Fixed-priority decode of the configuration bits
    always_comb begin
        if (vect_int_i) begin
            mode_o = VM_PRIORITY;
        end else if (vect_ext_i) begin
            mode_o = VM_EXTERNAL;
        end else if (iv_i) begin
            mode_o = VM_DEDICATED;
        end else begin
            mode_o = VM_GENERAL;
        end
    end

endmodule

// File: rtl/vio_prio_scan.sv
// Priority scanner.
// Returns the index of the highest set bit of req_i among bits N-1..1.
// Assumes bit 0 never selects a vector of its own, so an empty scan yields 0.
module vio_prio_scan #(
    parameter int unsigned N = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [N-1:0] above;   // above[i]: some bit strictly above i is set

    // Chain that marks every position that has a set bit above it
    generate
        for (genvar g = 0; g < N; g++) begin : g_above
            if (g == N - 1) begin : g_top
                assign above[g] = 1'b0;
            end else begin : g_rest
                assign above[g] = above[g+1] | req_i[g+1];
            end
        end
    endgenerate

    // One-hot pick of the top set bit, encoded to an index
    always_comb begin
        idx_o = '0;
        for (int i = 1; i < N; i++) begin
            if (req_i[i] && !above[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vio_offset_calc.sv
// Offset calculator.
// Scales the vector number by the spacing (in 32-byte units) and adds the vectored base.
// In the two non-vectored schemes it returns the fixed entry offset.
// Assumes OFF_W is wide enough for the largest product plus the base.
module vio_offset_calc
    import vio_pkg::*;
#(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned SPC_W = 5,
    parameter int unsigned OFF_W = 19
) (
    input  vmode_e           mode_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [SPC_W-1:0] spc_i,
    output logic [OFF_W-1:0] offset_o
);

    logic [OFF_W-1:0] vec_x;
    logic [OFF_W-1:0] stride;
    logic [OFF_W-1:0] scaled;

    // Widen operands and form the byte stride
    always_comb begin
        vec_x  = OFF_W'(vec_i);
        stride = OFF_W'(spc_i) << SPACING_SHIFT;
        scaled = vec_x * stride;
    end

    // Select the offset for the resolved scheme
    always_comb begin
        unique case (mode_i)
            VM_GENERAL:   offset_o = OFF_W'(GENERAL_OFFSET);
            VM_DEDICATED: offset_o = OFF_W'(VECTOR_BASE);
            default:      offset_o = OFF_W'(VECTOR_BASE) + scaled;
        endcase
    end

endmodule

// File: rtl/vio_offset_gen.sv
// Vectored interrupt offset generator (top).
// Masks the pending lines, resolves a vector number from the selected scheme,
// and produces the offset from the exception base. Both outputs are
// combinational, and a registered copy is provided.
// Assumes the inputs are stable around the clock edge that loads the copy.
module vio_offset_gen
    import vio_pkg::*;
#(
    parameter int unsigned IRQ_W = 8,
    parameter int unsigned SPC_W = 5,
    localparam int unsigned IDX_W = $clog2(IRQ_W),
    localparam int unsigned OFF_W = IRQ_W + SPC_W + SPACING_SHIFT + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] pend_i,
    input  logic [IRQ_W-1:0] mask_i,
    input  logic             iv_i,
    input  logic             vect_int_i,
    input  logic             vect_ext_i,
    input  logic [SPC_W-1:0] spacing_i,
    output logic [OFF_W-1:0] offset_o,
    output logic [IRQ_W-1:0] vector_o,
    output logic [OFF_W-1:0] offset_q,
    output logic [IRQ_W-1:0] vector_q
);

    logic [IRQ_W-1:0] eff_pend;
    logic [IDX_W-1:0] scan_idx;
    vmode_e           mode;

    // Pending lines gated by their enables
    assign eff_pend = pend_i & mask_i;

    vio_mode_sel u_mode (
        .iv_i       (iv_i),
        .vect_int_i (vect_int_i),
        .vect_ext_i (vect_ext_i),
        .mode_o     (mode)
    );

    vio_prio_scan #(.N(IRQ_W)) u_scan (
        .req_i (eff_pend),
        .idx_o (scan_idx)
    );

    // Vector number for the resolved scheme
    always_comb begin
        unique case (mode)
            VM_PRIORITY: vector_o = IRQ_W'(scan_idx);
            VM_EXTERNAL: vector_o = eff_pend;
            default:     vector_o = '0;
        endcase
    end

    vio_offset_calc #(
        .VEC_W (IRQ_W),
        .SPC_W (SPC_W),
        .OFF_W (OFF_W)
    ) u_calc (
        .mode_i   (mode),
        .vec_i    (vector_o),
        .spc_i    (spacing_i),
        .offset_o (offset_o)
    );

    // Registered copy of the result for timing closure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
            vector_q <= '0;
        end else begin
            offset_q <= offset_o;
            vector_q <= vector_o;
        end
    end

endmodule

// File: rtl/vio_offset_gen_chk.sv
// Checker for the vectored interrupt offset generator.
// It watches the ports only and is attached to the top with a bind.
module vio_offset_gen_chk #(
    parameter int unsigned IRQ_W = 8,
    parameter int unsigned SPC_W = 5,
    parameter int unsigned OFF_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IRQ_W-1:0] pend_i,
    input logic [IRQ_W-1:0] mask_i,
    input logic             iv_i,
    input logic             vect_int_i,
    input logic             vect_ext_i,
    input logic [SPC_W-1:0] spacing_i,
    input logic [OFF_W-1:0] offset_o,
    input logic [IRQ_W-1:0] vector_o,
    input logic [OFF_W-1:0] offset_q,
    input logic [IRQ_W-1:0] vector_q
);

    logic [IRQ_W-1:0] seen;
    assign seen = pend_i & mask_i;

    // R2
    prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vect_int_i && vector_o != '0) |->
            (((seen >> vector_o) & IRQ_W'(1)) != '0) && ((seen >> vector_o) >> 1) == '0);

    // R3
    prio_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vect_int_i && (seen >> 1) == '0) |-> vector_o == '0);

    // R4
    ext_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vect_int_i && vect_ext_i) |-> vector_o == seen);

    // R7
    dedicated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vect_int_i && !vect_ext_i && iv_i) |-> (offset_o == OFF_W'(32'h200) && vector_o == '0));

    // R8
    general_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vect_int_i && !vect_ext_i && !iv_i) |-> (offset_o == OFF_W'(32'h180) && vector_o == '0));

    // R9
    zero_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((vect_int_i || vect_ext_i) && spacing_i == '0) |-> offset_o == OFF_W'(32'h200));

    // R10
    copy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (offset_q == $past(offset_o) && vector_q == $past(vector_o)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (offset_q == '0 && vector_q == '0));

endmodule

bind vio_offset_gen vio_offset_gen_chk #(
    .IRQ_W (IRQ_W),
    .SPC_W (SPC_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend_i),
    .mask_i     (mask_i),
    .iv_i       (iv_i),
    .vect_int_i (vect_int_i),
    .vect_ext_i (vect_ext_i),
    .spacing_i  (spacing_i),
    .offset_o   (offset_o),
    .vector_o   (vector_o),
    .offset_q   (offset_q),
    .vector_q   (vector_q)
);

// File: tb/vio_offset_gen_test.sv
// Self-checking bench: a table walk, then directed reset, sweep and masking tests.
module vio_offset_gen_test;

    localparam int CLK_P = 10;
    localparam int ENT_W = 8 + 8 + 1 + 1 + 1 + 5 + 8 + 19;
    localparam int N_ENT = 14;

    // {pend, mask, iv, vint, vext, spacing, exp_vector, exp_offset}
    localparam logic [ENT_W-1:0] TBL [N_ENT] = '{
        {8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 5'd1,  8'd7,  19'h002E0}, // R2
        {8'h28, 8'hFF, 1'b0, 1'b1, 1'b0, 5'd2,  8'd5,  19'h00340}, // R2
        {8'h28, 8'h0F, 1'b0, 1'b1, 1'b0, 5'd2,  8'd3,  19'h002C0}, // R1
        {8'h01, 8'hFF, 1'b0, 1'b1, 1'b0, 5'd4,  8'd0,  19'h00200}, // R3
        {8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 5'd4,  8'd0,  19'h00200}, // R3
        {8'h5A, 8'hFF, 1'b0, 1'b0, 1'b1, 5'd1,  8'd90, 19'h00D40}, // R4
        {8'hFF, 8'h3C, 1'b0, 1'b0, 1'b1, 5'd31, 8'd60, 19'h0EA80}, // R4
        {8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 5'd31, 8'd255,19'h3DE20}, // R5
        {8'h5A, 8'hFF, 1'b0, 1'b1, 1'b1, 5'd1,  8'd6,  19'h002C0}, // R6
        {8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 5'd5,  8'd0,  19'h00200}, // R7
        {8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 5'd5,  8'd0,  19'h00180}, // R8
        {8'h5A, 8'hFF, 1'b0, 1'b0, 1'b1, 5'd0,  8'd90, 19'h00200}, // R9
        {8'h80, 8'hFF, 1'b0, 1'b1, 1'b0, 5'd0,  8'd7,  19'h00200}, // R9
        {8'h03, 8'h02, 1'b0, 1'b1, 1'b0, 5'd3,  8'd1,  19'h00260}  // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pend_i = '0;
    logic [7:0]  mask_i = '0;
    logic        iv_i = 1'b0;
    logic        vect_int_i = 1'b0;
    logic        vect_ext_i = 1'b0;
    logic [4:0]  spacing_i = '0;
    logic [18:0] offset_o;
    logic [7:0]  vector_o;
    logic [18:0] offset_q;
    logic [7:0]  vector_q;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    vio_offset_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_i),
        .mask_i     (mask_i),
        .iv_i       (iv_i),
        .vect_int_i (vect_int_i),
        .vect_ext_i (vect_ext_i),
        .spacing_i  (spacing_i),
        .offset_o   (offset_o),
        .vector_o   (vector_o),
        .offset_q   (offset_q),
        .vector_q   (vector_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] p, input logic [7:0] m, input logic iv,
                         input logic vi, input logic ve, input logic [4:0] s);
        pend_i = p; mask_i = m; iv_i = iv;
        vect_int_i = vi; vect_ext_i = ve; spacing_i = s;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R10 reset state, with inputs that would give nonzero results
        drive(8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 5'd3);
        repeat (2) @(posedge clk);
        #1;
        chk("R10 reset offset_q", 32'(offset_q), 32'h0);
        chk("R10 reset vector_q", 32'(vector_q), 32'h0);
        rst_n = 1'b1;

        // Table walk: combinational now, registered after the next edge
        for (int i = 0; i < N_ENT; i++) begin
            logic [ENT_W-1:0] e;
            e = TBL[i];
            drive(e[50:43], e[42:35], e[34], e[33], e[32], e[31:27]);
            #1;
            chk($sformatf("table %0d vector", i), 32'(vector_o), 32'(e[26:19]));
            chk($sformatf("table %0d offset", i), 32'(offset_o), 32'(e[18:0]));
            @(posedge clk);
            #1;
            chk($sformatf("R10 table %0d offset_q", i), 32'(offset_q), 32'(e[18:0]));
            chk($sformatf("R10 table %0d vector_q", i), 32'(vector_q), 32'(e[26:19]));
        end

        // R2 R5 sweep: each single top bit, with bit 0 also pending
        for (int v = 1; v < 8; v++) begin
            drive(8'((1 << v) | 1), 8'hFF, 1'b0, 1'b1, 1'b0, 5'(v + 1));
            #1;
            chk("R2 sweep vector", 32'(vector_o), 32'(v));
            chk("R5 sweep offset", 32'(offset_o), 32'(32'h200 + v * (v + 1) * 32));
        end

        // R1: masked-off top line is ignored in external mode
        drive(8'hC1, 8'h7F, 1'b0, 1'b0, 1'b1, 5'd1);
        #1;
        chk("R1 masked ext vector", 32'(vector_o), 32'h41);
        chk("R1 masked ext offset", 32'(offset_o), 32'(32'h200 + 32'h41 * 32));

        // R10: reset in mid-run clears the copy
        drive(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 5'd31);
        @(posedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R10 mid reset offset_q", 32'(offset_q), 32'h0);
        chk("R10 mid reset vector_q", 32'(vector_q), 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 after reset offset_q", 32'(offset_q), 32'h3DE20);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule